// File: doc/BRIEF.md
# Multi-Rail Hot-Swap Power Sequencer

This block is the digital control core for the four supply switches of a plug-in board. Rail index fixes the supply: bit 0 is the 12 V rail, bit 1 the 5 V rail, bit 2 the 3.3 V rail and bit 3 the −12 V rail. The block first waits for an active-low card-select input to settle. It then powers the rails in one of three ways. They can all come on at once. They can come on one after another in the fixed order 12 V, 5 V, 3.3 V, −12 V. Or they can follow a host-written enable mask. Analog measurement stays outside the block and arrives as digital flags: a per-rail good flag, a per-rail current-limit flag, an external power-good input and a fault-shutdown request.

After the rails are switched on, a start-up window runs. During this window current-limit flags have no effect. When the window ends, the block asserts an active-low board-ok output, but only if every enabled rail reports good. Once board-ok is asserted, a gated board reset follows the incoming bus reset. A power-good timeout follows board-ok. A current limit that is still present after the window, or a shutdown request, starts a cool-down. From the cool-down the block either retries or stays latched off. Every delay is a count of clock cycles set by a parameter. All control and status pins are plain levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `hsq_rail_sequencer`

## Requirements
- R1: While card_sel_n is sampled high the qualifier restarts. The rails stay off until card_sel_n has been sampled low on QUAL_CYC consecutive rising edges. The first rail switches on at the following edge.
- R2: If auto_on is high at qualification and the sequence request latched was 0, rail_en becomes 4'b1111 in a single step.
- R3: If auto_on is low at qualification, rail_en stays 0 until host_on is nonzero. From then on rail_en equals host_on. If host_on returns to 0, rail_en returns to 0 and board_ok_n is deasserted.
- R4: seq_req is captured on every edge where card_sel_n is high and is frozen while it is low. A captured 1 makes rail_en step through 0001, 0011, 0111 and 1111. Each step happens on the edge after the newest rail reports good. The start-up window begins after the last rail is good.
- R5: In sequenced mode, if the newest rail is not good within STEP_CYC cycles of being enabled, all rails turn off, step_timeout goes to 1 and a cool-down begins.
- R6: The start-up window lasts START_CYC cycles, and rail_ilim is ignored during it. When it ends, board_ok_n goes low only once every enabled rail is good. Until then the block waits with the rails on.
- R7: gated_rst_n is 0 whenever board_ok_n is 1. While board_ok_n is 0, gated_rst_n equals in_rst_n.
- R8: A current limit on an enabled rail after the start-up window turns all rails off. It also drives cooling to 1 for COOL_CYC cycles.
- R9: When the cool-down ends, the block restarts qualification if retry_en is 1. If retry_en is 0, the rails stay off until the card is removed.
- R10: PGI_CYC cycles after board_ok_n falls, ext_pwr_ok is checked once. If it is low, all rails turn off and stay latched off. Later changes of ext_pwr_ok have no effect.
- R11: One edge after card_sel_n is sampled high, all rails are off, board_ok_n is 1, gated_rst_n is 0 and step_timeout is 0.
- R12: While any rail is enabled, fault_req turns all rails off on the next edge and starts a cool-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_sel_n | input | 1 | Active-low card-present select |
| auto_on | input | 1 | 1: automatic turn-on, 0: host mask control |
| seq_req | input | 1 | Request for sequenced turn-on, captured while the card is absent |
| retry_en | input | 1 | Restart automatically after a cool-down |
| host_on | input | 4 | Host enable mask, one bit per rail |
| rail_good | input | 4 | Rail above its power-bad threshold |
| rail_ilim | input | 4 | Rail in current limit |
| fault_req | input | 1 | Shutdown request |
| ext_pwr_ok | input | 1 | External power-good input |
| in_rst_n | input | 1 | Incoming bus reset, active low |
| rail_en | output | 4 | Switch enables |
| board_ok_n | output | 1 | Active-low board healthy |
| gated_rst_n | output | 1 | Local board reset, active low |
| step_timeout | output | 1 | A sequenced step timed out |
| cooling | output | 1 | Cool-down in progress |

## Verification
The assertions take it as given that every input is already synchronous to clk and changes only between edges. They also take it that rail_good and rail_ilim are flags the block can sample directly, with no filtering of its own. The bench respects this by changing every input one nanosecond after a rising edge, so each value is stable for the whole cycle. It also holds host_on steady except at the moments a test means to change it. The reference model sees the same sampled values the design does.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  localparam int unsigned RAILS = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOST, ST_SEQ, ST_START, ST_PGI, ST_STEADY, ST_COOL, ST_LATCH
  } hsq_state_e;

  typedef enum logic [1:0] {MD_AUTO, MD_SEQ, MD_HOST} hsq_mode_e;

  function automatic int hsq_max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/hsq_card_qual.sv
module hsq_card_qual #(
  parameter int QUAL_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_sel_n,
  input  logic seq_req,
  output logic qualified,
  output logic seq_latched
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

  logic [QW-1:0] cnt_q;
  logic          lat_q;

  // restart on every high sample, saturate once qualified
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else if (card_sel_n) begin
      cnt_q <= '0;
      lat_q <= seq_req;
    end else if (cnt_q != QMAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qualified   = (cnt_q == QMAX);
  assign seq_latched = lat_q;

  AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    card_sel_n |=> !qualified); // R1
endmodule

// File: rtl/hsq_countdown.sv
module hsq_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/hsq_rail_mask.sv
module hsq_rail_mask
  import hsq_pkg::*;
#(
  parameter int N = RAILS
) (
  input  hsq_state_e              state,
  input  hsq_mode_e               mode,
  input  logic [$clog2(N)-1:0]    step,
  input  logic [N-1:0]            host_on,
  input  logic [N-1:0]            rail_good,
  input  logic [N-1:0]            rail_ilim,
  output logic [N-1:0]            rail_en,
  output logic                    all_good,
  output logic                    any_ilim,
  output logic                    cur_good
);
  localparam int SW = $clog2(N);

  logic          on_phase;
  logic [N-1:0]  ok_v;
  logic [N-1:0]  lim_v;

  assign on_phase = (state == ST_START) || (state == ST_PGI) || (state == ST_STEADY);

  for (genvar r = 0; r < N; r++) begin : g_rail
    assign rail_en[r] = (state == ST_SEQ) ? (SW'(r) <= step) :
                        on_phase ? ((mode == MD_HOST) ? host_on[r] : 1'b1) : 1'b0;
    assign ok_v[r]  = rail_good[r] | ~rail_en[r];
    assign lim_v[r] = rail_ilim[r] & rail_en[r];
  end

  assign all_good = &ok_v;
  assign any_ilim = |lim_v;
  assign cur_good = rail_good[step];
endmodule

// File: rtl/hsq_ctrl_fsm.sv
module hsq_ctrl_fsm
  import hsq_pkg::*;
#(
  parameter int START_CYC = 16,
  parameter int STEP_CYC  = 12,
  parameter int PGI_CYC   = 10,
  parameter int COOL_CYC  = 784
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      card_sel_n,
  input  logic                      qualified,
  input  logic                      seq_latched,
  input  logic                      auto_on,
  input  logic                      retry_en,
  input  logic                      fault_req,
  input  logic                      ext_pwr_ok,
  input  logic [RAILS-1:0]          host_on,
  input  logic                      all_good,
  input  logic                      any_ilim,
  input  logic                      cur_good,
  output hsq_state_e                state_o,
  output hsq_mode_e                 mode_o,
  output logic [$clog2(RAILS)-1:0]  step_o,
  output logic                      timeout_o
);
  localparam int SW   = $clog2(RAILS);
  localparam int MAXC = hsq_max4(START_CYC, STEP_CYC, PGI_CYC, COOL_CYC);
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] START_LD = TW'(START_CYC - 1);
  localparam logic [TW-1:0] STEP_LD  = TW'(STEP_CYC - 1);
  localparam logic [TW-1:0] PGI_LD   = TW'(PGI_CYC - 1);
  localparam logic [TW-1:0] COOL_LD  = TW'(COOL_CYC - 1);
  localparam logic [SW-1:0] LAST     = SW'(RAILS - 1);

  hsq_state_e    st_q, st_d;
  hsq_mode_e     md_q, md_d;
  logic [SW-1:0] step_q, step_d;
  logic          flt_q, flt_d;
  logic          ld;
  logic [TW-1:0] ld_val;
  logic          expired;
  logic          host_drop;

  hsq_countdown #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(expired)
  );

  assign host_drop = (md_q == MD_HOST) && (host_on == '0);

  always_comb begin
    st_d   = st_q;
    md_d   = md_q;
    step_d = step_q;
    flt_d  = flt_q;
    ld     = 1'b0;
    ld_val = '0;
    if (card_sel_n) begin
      st_d   = ST_IDLE;
      step_d = '0;
      flt_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (qualified) begin
          step_d = '0;
          if (!auto_on) begin
            st_d = ST_HOST; md_d = MD_HOST;
          end else if (seq_latched) begin
            st_d = ST_SEQ; md_d = MD_SEQ; ld = 1'b1; ld_val = STEP_LD;
          end else begin
            st_d = ST_START; md_d = MD_AUTO; ld = 1'b1; ld_val = START_LD;
          end
        end
        ST_HOST: if (host_on != '0) begin
          st_d = ST_START; ld = 1'b1; ld_val = START_LD;
        end
        ST_SEQ: begin
          if (fault_req) begin
            st_d = ST_COOL; ld = 1'b1; ld_val = COOL_LD;
          end else if (cur_good) begin
            ld = 1'b1;
            if (step_q == LAST) begin
              st_d = ST_START; ld_val = START_LD;
            end else begin
              step_d = step_q + 1'b1; ld_val = STEP_LD;
            end
          end else if (expired) begin
            flt_d = 1'b1; st_d = ST_COOL; ld = 1'b1; ld_val = COOL_LD;
          end
        end
        ST_START: begin
          if (fault_req) begin
            st_d = ST_COOL; ld = 1'b1; ld_val = COOL_LD;
          end else if (host_drop) begin
            st_d = ST_HOST;
          end else if (expired) begin
            if (any_ilim) begin
              st_d = ST_COOL; ld = 1'b1; ld_val = COOL_LD;
            end else if (all_good) begin
              st_d = ST_PGI; ld = 1'b1; ld_val = PGI_LD;
            end
          end
        end
        ST_PGI: begin
          if (fault_req || any_ilim) begin
            st_d = ST_COOL; ld = 1'b1; ld_val = COOL_LD;
          end else if (host_drop) begin
            st_d = ST_HOST;
          end else if (expired) begin
            st_d = ext_pwr_ok ? ST_STEADY : ST_LATCH;
          end
        end
        ST_STEADY: begin
          if (fault_req || any_ilim) begin
            st_d = ST_COOL; ld = 1'b1; ld_val = COOL_LD;
          end else if (host_drop) begin
            st_d = ST_HOST;
          end
        end
        ST_COOL: if (expired) st_d = retry_en ? ST_IDLE : ST_LATCH;
        ST_LATCH: st_d = ST_LATCH;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      md_q   <= MD_AUTO;
      step_q <= '0;
      flt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      md_q   <= md_d;
      step_q <= step_d;
      flt_q  <= flt_d;
    end
  end

  assign state_o   = st_q;
  assign mode_o    = md_q;
  assign step_o    = step_q;
  assign timeout_o = flt_q;

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCH && !card_sel_n) |=> (st_q == ST_LATCH)); // R9
endmodule

// File: rtl/hsq_rail_sequencer.sv
module hsq_rail_sequencer
  import hsq_pkg::*;
#(
  parameter int QUAL_CYC  = 20,
  parameter int START_CYC = 16,
  parameter int STEP_CYC  = 12,
  parameter int PGI_CYC   = 10,
  parameter int COOL_CYC  = 784
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_sel_n,
  input  logic             auto_on,
  input  logic             seq_req,
  input  logic             retry_en,
  input  logic [RAILS-1:0] host_on,
  input  logic [RAILS-1:0] rail_good,
  input  logic [RAILS-1:0] rail_ilim,
  input  logic             fault_req,
  input  logic             ext_pwr_ok,
  input  logic             in_rst_n,
  output logic [RAILS-1:0] rail_en,
  output logic             board_ok_n,
  output logic             gated_rst_n,
  output logic             step_timeout,
  output logic             cooling
);
  localparam int SW = $clog2(RAILS);

  logic          qualified, seq_latched;
  logic          all_good, any_ilim, cur_good;
  hsq_state_e    state;
  hsq_mode_e     mode;
  logic [SW-1:0] step;
  logic          healthy;

  hsq_card_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .card_sel_n(card_sel_n), .seq_req(seq_req),
    .qualified(qualified), .seq_latched(seq_latched)
  );

  hsq_ctrl_fsm #(
    .START_CYC(START_CYC), .STEP_CYC(STEP_CYC), .PGI_CYC(PGI_CYC), .COOL_CYC(COOL_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .card_sel_n(card_sel_n), .qualified(qualified),
    .seq_latched(seq_latched), .auto_on(auto_on), .retry_en(retry_en),
    .fault_req(fault_req), .ext_pwr_ok(ext_pwr_ok), .host_on(host_on),
    .all_good(all_good), .any_ilim(any_ilim), .cur_good(cur_good),
    .state_o(state), .mode_o(mode), .step_o(step), .timeout_o(step_timeout)
  );

  hsq_rail_mask #(.N(RAILS)) u_mask (
    .state(state), .mode(mode), .step(step), .host_on(host_on),
    .rail_good(rail_good), .rail_ilim(rail_ilim), .rail_en(rail_en),
    .all_good(all_good), .any_ilim(any_ilim), .cur_good(cur_good)
  );

  assign healthy     = (state == ST_PGI) || (state == ST_STEADY);
  assign board_ok_n  = ~healthy;
  assign gated_rst_n = healthy & in_rst_n;
  assign cooling     = (state == ST_COOL);

  AST_RAILS_NEED_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|rail_en) |-> qualified); // R1
  AST_ONE_RAIL_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEQ) |=> ($countones(rail_en) <= $countones($past(rail_en)) + 1)); // R4
  AST_OK_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(board_ok_n) |-> (&$past(rail_good | ~rail_en))); // R6
  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    board_ok_n |-> !gated_rst_n); // R7
  AST_COOL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    cooling |-> (rail_en == '0)); // R8
  AST_DROP_ON_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
    card_sel_n |=> ((rail_en == '0) && board_ok_n && !gated_rst_n && !step_timeout)); // R11
endmodule

// File: tb/hsq_rail_sequencer_tb_top.sv
`timescale 1ns/1ps
module hsq_rail_sequencer_tb_top;
  localparam int QC = 20, SC = 16, TC = 12, PC = 10, CC = 784;
  localparam int M_IDLE = 0, M_HOST = 1, M_SEQ = 2, M_START = 3, M_PGI = 4,
                 M_STEADY = 5, M_COOL = 6, M_LATCH = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_sel_n = 1'b1, auto_on = 1'b1, seq_req = 1'b0, retry_en = 1'b0;
  logic [3:0] host_on = 4'h0, rail_good = 4'h0, rail_ilim = 4'h0;
  logic fault_req = 1'b0, ext_pwr_ok = 1'b1, in_rst_n = 1'b1;
  logic [3:0] rail_en;
  logic board_ok_n, gated_rst_n, step_timeout, cooling;

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  hsq_rail_sequencer #(.QUAL_CYC(QC), .START_CYC(SC), .STEP_CYC(TC),
    .PGI_CYC(PC), .COOL_CYC(CC)) dut_i (
    .clk(clk), .rst_n(rst_n), .card_sel_n(card_sel_n), .auto_on(auto_on),
    .seq_req(seq_req), .retry_en(retry_en), .host_on(host_on),
    .rail_good(rail_good), .rail_ilim(rail_ilim), .fault_req(fault_req),
    .ext_pwr_ok(ext_pwr_ok), .in_rst_n(in_rst_n), .rail_en(rail_en),
    .board_ok_n(board_ok_n), .gated_rst_n(gated_rst_n),
    .step_timeout(step_timeout), .cooling(cooling));

  // behavioural reference model
  int m_st = M_IDLE, m_e = 0, m_deb = 0, m_step = 0, m_md = 0, nst = 0;
  bit m_seql = 0, m_flt = 0, mq = 0, mlim = 0, mgood = 0, hdrop = 0;

  function automatic logic [3:0] m_en();
    if (m_st == M_SEQ) return 4'((1 << (m_step + 1)) - 1);
    if (m_st == M_START || m_st == M_PGI || m_st == M_STEADY)
      return (m_md == 2) ? host_on : 4'hF;
    return 4'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_e = 0; m_deb = 0; m_step = 0; m_md = 0; m_seql = 0; m_flt = 0;
    end else begin
      mq    = (m_deb >= QC);
      mlim  = |(rail_ilim & m_en());
      mgood = &(rail_good | ~m_en());
      hdrop = (m_md == 2) && (host_on == 4'h0);
      m_e   = m_e + 1;
      nst   = m_st;
      if (card_sel_n) begin
        nst = M_IDLE; m_step = 0; m_flt = 0;
      end else begin
        case (m_st)
          M_IDLE: if (mq) begin
            m_step = 0;
            if (!auto_on) begin nst = M_HOST; m_md = 2; end
            else if (m_seql) begin nst = M_SEQ; m_md = 1; end
            else begin nst = M_START; m_md = 0; end
          end
          M_HOST: if (host_on != 4'h0) nst = M_START;
          M_SEQ: begin
            if (fault_req) nst = M_COOL;
            else if (rail_good[m_step]) begin
              if (m_step == 3) nst = M_START;
              else begin m_step = m_step + 1; m_e = 0; end
            end else if (m_e >= TC) begin m_flt = 1; nst = M_COOL; end
          end
          M_START: begin
            if (fault_req) nst = M_COOL;
            else if (hdrop) nst = M_HOST;
            else if (m_e >= SC) begin
              if (mlim) nst = M_COOL;
              else if (mgood) nst = M_PGI;
            end
          end
          M_PGI: begin
            if (fault_req || mlim) nst = M_COOL;
            else if (hdrop) nst = M_HOST;
            else if (m_e >= PC) nst = ext_pwr_ok ? M_STEADY : M_LATCH;
          end
          M_STEADY: begin
            if (fault_req || mlim) nst = M_COOL;
            else if (hdrop) nst = M_HOST;
          end
          M_COOL: if (m_e >= CC) nst = retry_en ? M_IDLE : M_LATCH;
          default: nst = m_st;
        endcase
      end
      if (nst != m_st) m_e = 0;
      m_st = nst;
      if (card_sel_n) begin m_deb = 0; m_seql = seq_req; end
      else m_deb = m_deb + 1;
    end
  end

  // every-cycle comparison against the model, mid-cycle
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [3:0] e_en;
      logic e_ok_n, e_rst;
      e_en   = m_en();
      e_ok_n = !(m_st == M_PGI || m_st == M_STEADY);
      e_rst  = !e_ok_n && in_rst_n;
      checks++;
      if (rail_en !== e_en || board_ok_n !== e_ok_n || gated_rst_n !== e_rst ||
          step_timeout !== m_flt || cooling !== (m_st == M_COOL)) begin
        errors++;
        $display("FAIL %s model: act en=%b ok_n=%b rst=%b to=%b cool=%b exp en=%b ok_n=%b rst=%b to=%b cool=%b",
                 cur_req, rail_en, board_ok_n, gated_rst_n, step_timeout, cooling,
                 e_en, e_ok_n, e_rst, m_flt, (m_st == M_COOL));
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    cmp_on = 1;
    chk("R11 reset rails", rail_en, 0);
    chk("R11 reset ok_n", board_ok_n, 1);
    chk("R7 reset gated", gated_rst_n, 0);

    // auto turn-on, window, healthy, reset follow, power-good check
    cur_req = "R1";
    rail_good = 4'hF; card_sel_n = 1'b0;
    cyc(QC);      chk("R1 still off", rail_en, 0);
    cyc(1);       chk("R2 all on", rail_en, 4'hF);
    cur_req = "R6";
    chk("R6 ok_n in window", board_ok_n, 1);
    rail_ilim = 4'hF;
    cyc(SC - 2);  chk("R6 ilim ignored", rail_en, 4'hF);
    rail_ilim = 4'h0;
    cyc(2);       chk("R6 ok asserted", board_ok_n, 0);
    cur_req = "R7";
    chk("R7 follows high", gated_rst_n, 1);
    in_rst_n = 1'b0; #0.5;
    chk("R7 follows low", gated_rst_n, 0);
    in_rst_n = 1'b1;
    cur_req = "R10";
    cyc(PC + 2);  chk("R10 pass", board_ok_n, 0);
    ext_pwr_ok = 1'b0;
    cyc(5);       chk("R10 ignored later", rail_en, 4'hF);
    ext_pwr_ok = 1'b1;

    // shutdown request, cool-down, retry
    cur_req = "R12";
    fault_req = 1'b1; retry_en = 1'b1;
    cyc(1);       chk("R12 off", rail_en, 0);
    chk("R12 cooling", cooling, 1);
    fault_req = 1'b0;
    cur_req = "R8";
    cyc(CC - 1);  chk("R8 cool length", cooling, 1);
    cyc(1);       chk("R8 cool end", cooling, 0);
    cur_req = "R9";
    cyc(1);       chk("R9 retry on", rail_en, 4'hF);

    // removal
    cur_req = "R11";
    card_sel_n = 1'b1; retry_en = 1'b0;
    cyc(1);       chk("R11 removal rails", rail_en, 0);
    chk("R11 removal ok_n", board_ok_n, 1);
    chk("R11 removal gated", gated_rst_n, 0);

    // power-good timeout failure
    cur_req = "R10";
    ext_pwr_ok = 1'b0; card_sel_n = 1'b0;
    cyc(QC + 1 + SC);
    chk("R10 ok asserted first", board_ok_n, 0);
    cyc(PC - 1);  chk("R10 before check", board_ok_n, 0);
    cyc(1);       chk("R10 latched off", rail_en, 0);
    ext_pwr_ok = 1'b1;
    cyc(20);      chk("R10 stays off", rail_en, 0);
    card_sel_n = 1'b1; cyc(2);

    // wait for rails after window
    cur_req = "R6";
    rail_good = 4'b0111; card_sel_n = 1'b0;
    cyc(QC + 1 + SC + 3);
    chk("R6 waits", board_ok_n, 1);
    chk("R6 rails held", rail_en, 4'hF);
    rail_good = 4'hF;
    cyc(1);       chk("R6 late ok", board_ok_n, 0);
    card_sel_n = 1'b1; cyc(2);

    // current limit at window end, no retry
    cur_req = "R8";
    card_sel_n = 1'b0;
    cyc(QC + 1 + SC - 1);
    rail_ilim = 4'b0010;
    cyc(1);       chk("R8 ilim off", rail_en, 0);
    chk("R8 cooling", cooling, 1);
    rail_ilim = 4'h0;
    cur_req = "R9";
    cyc(CC);      chk("R9 latched", cooling, 0);
    cyc(10);      chk("R9 stays off", rail_en, 0);
    card_sel_n = 1'b1; cyc(2);

    // sequenced order
    cur_req = "R4";
    seq_req = 1'b1; rail_good = 4'h0;
    cyc(1);
    card_sel_n = 1'b0; seq_req = 1'b0;
    cyc(QC + 1);  chk("R4 step 12V", rail_en, 4'b0001);
    rail_good = 4'b0001; cyc(1); chk("R4 step 5V", rail_en, 4'b0011);
    rail_good = 4'b0011; cyc(1); chk("R4 step 3V3", rail_en, 4'b0111);
    rail_good = 4'b0111; cyc(1); chk("R4 step neg", rail_en, 4'b1111);
    rail_good = 4'hF;    cyc(1); chk("R4 window on", board_ok_n, 1);
    cyc(SC);      chk("R4 ok after seq", board_ok_n, 0);
    card_sel_n = 1'b1; cyc(2);

    // step timeout
    cur_req = "R5";
    seq_req = 1'b1; rail_good = 4'b0001;
    cyc(1);
    card_sel_n = 1'b0;
    cyc(QC + 1);
    cyc(1);       chk("R5 step two", rail_en, 4'b0011);
    cyc(TC - 1);  chk("R5 before timeout", step_timeout, 0);
    cyc(1);       chk("R5 timeout flag", step_timeout, 1);
    chk("R5 rails off", rail_en, 0);
    cur_req = "R11";
    card_sel_n = 1'b1;
    cyc(1);       chk("R11 flag cleared", step_timeout, 0);
    seq_req = 1'b0; cyc(1);

    // host mask
    cur_req = "R3";
    auto_on = 1'b0; rail_good = 4'hF; card_sel_n = 1'b0;
    cyc(QC + 6);  chk("R3 waits host", rail_en, 0);
    host_on = 4'b0101;
    cyc(1);       chk("R3 mask", rail_en, 4'b0101);
    cyc(SC);      chk("R3 ok", board_ok_n, 0);
    host_on = 4'h0;
    cyc(1);       chk("R3 drop ok_n", board_ok_n, 1);
    chk("R3 drop rails", rail_en, 0);
    card_sel_n = 1'b1; cyc(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule